// File: doc/BRIEF.md
# Scaler Pool Request Validator and Allocator

This block sits between the users of a display pipe (a set of planes plus one pipe-level user) and a small pool of scaler instances. A user presents one scaling request at a time: its index, its source and destination sizes, and a few format flags. The block decides whether the request needs a scaler at all. It checks the request against interlace, minimum-size, pool-occupancy and scale-ratio rules. If every rule passes, it binds the user to a scaler and reports the outcome as a single-cycle response carrying a result code and the scaler index.

Scale ratios are source size in 16.16 fixed point divided by destination size, computed by two sequential restoring dividers that run in parallel. Whether a ratio is acceptable depends on which scaler would be granted and on the output format. When the pool holds exactly one user, that user is steered to scaler 0 in high-quality mode. Otherwise every bound scaler runs in dynamic mode. A separate release input unbinds a user at any idle cycle. Per-scaler in-use and high-quality flags are driven from registers.

Top module: `scaler_grant_ctrl`

## Requirements
- R1: After reset, all scaler in-use and high-quality flags are 0, resp_valid is 0 and req_ready is 1.
- R2: A request whose source equals its destination in both axes and that is not semiplanar on a non-HDR plane needs no scaler. It answers code 1 (bypass) and frees any scaler the user held.
- R3: A request that needs a scaler while req_interlaced is 1 answers code 2. This check ranks above every other check.
- R4: A source below 8 in either axis (16 when req_semiplanar is 1), or a destination below 8 in either axis, answers code 3 and leaves the pool unchanged.
- R5: When the count of users holding scalers, including the requester, would exceed NUM_SCALERS, the request answers code 4 and leaves the pool unchanged.
- R6: A successful request answers code 0 with resp_scaler set to the user's scaler. That is the scaler the user already holds, or else the lowest-indexed free scaler, and its in-use flag is 1.
- R7: When the requester would be the only user, it is granted scaler 0 with its high-quality flag set. A grant that leaves two or more users clears every high-quality flag.
- R8: The ratio per axis is floor(src*65536/dst). A ratio above 0x2FFFF in either axis answers code 5 and leaves the pool unchanged.
- R9: With NEWEST_VARIANT set, a vertical ratio above 0x10000 is rejected with code 5 on any scaler other than 0.
- R10: For the pipe user (index NUM_USERS-1) with req_out420 set, a horizontal ratio above 0x17FFF or a vertical ratio above 0x10000 answers code 5.
- R11: A release of a user that holds a scaler clears that scaler's in-use and high-quality flags. A release of a user holding none changes nothing.
- R12: Each accepted request yields exactly one resp_valid pulse of one cycle, and req_ready stays low from acceptance until that pulse. req_ready is also low in any cycle where rel_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_user | input | $clog2(NUM_USERS) | Requesting user index; highest is the pipe user |
| req_src_w | input | DIM_W | Source width |
| req_src_h | input | DIM_W | Source height |
| req_dst_w | input | DIM_W | Destination width |
| req_dst_h | input | DIM_W | Destination height |
| req_semiplanar | input | 1 | Source is semiplanar YUV |
| req_hdr_plane | input | 1 | Requesting plane has its own chroma upsampler |
| req_interlaced | input | 1 | Pipe output is interlaced |
| req_out420 | input | 1 | Pipe output is YUV 4:2:0 |
| rel_valid | input | 1 | Release request |
| rel_ready | output | 1 | Release taken this cycle when valid |
| rel_user | input | $clog2(NUM_USERS) | User to release |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_user | output | $clog2(NUM_USERS) | User the response belongs to |
| resp_code | output | 3 | 0 grant, 1 bypass, 2 interlace, 3 size, 4 count, 5 ratio |
| resp_scaler | output | max(1,$clog2(NUM_SCALERS)) | Granted scaler index (0 unless grant) |
| scaler_busy | output | NUM_SCALERS | Per-scaler in-use flags |
| scaler_hq | output | NUM_SCALERS | Per-scaler high-quality mode flags |

## Verification
The bench builds the block with four users, two scalers and NEWEST_VARIANT set to 1. A third concurrent user then overflows the pool, and the restricted vertical limit of scaler 1 becomes reachable. Directed requests sit on the exact ratio boundaries 3.0 and 1.5, and the 1.0 vertical limit. They also cover the single-user move to scaler 0 and the high-quality flag clearing on a second grant. Seeded random traffic mixes sizes, format flags and releases across all users.

// File: rtl/sgc_pkg.sv
package sgc_pkg;

  typedef enum logic [2:0] {
    RC_GRANT     = 3'd0,
    RC_BYPASS    = 3'd1,
    RC_INTERLACE = 3'd2,
    RC_SIZE      = 3'd3,
    RC_COUNT     = 3'd4,
    RC_RATIO     = 3'd5
  } resp_code_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_DIV   = 2'd2
  } ctrl_state_e;

  // ratio limits in 16.16
  localparam int unsigned LIM_FULL  = 32'h0002_FFFF;
  localparam int unsigned LIM_H420  = 32'h0001_7FFF;
  localparam int unsigned LIM_UNITY = 32'h0001_0000;

  localparam int unsigned MIN_SRC_PLAIN = 8;
  localparam int unsigned MIN_SRC_SEMI  = 16;
  localparam int unsigned MIN_DST       = 8;

  localparam int unsigned FRAC_BITS = 16;

endpackage

// File: rtl/sgc_ratio_div.sv
module sgc_ratio_div #(
  parameter int DIM_W = 14
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start_i,
  input  logic [DIM_W-1:0]            num_i,
  input  logic [DIM_W-1:0]            den_i,
  output logic [DIM_W+16-1:0]         quo_o,
  output logic                        done_o
);
  localparam int NUM_W = DIM_W + 16;
  localparam int CW    = $clog2(NUM_W + 1);
  localparam int PW    = NUM_W + DIM_W;

  logic [NUM_W-1:0] quo_r;
  logic [DIM_W:0]   rem_r;
  logic [DIM_W-1:0] den_r;
  logic [DIM_W-1:0] num_r;
  logic [CW-1:0]    cnt_r;
  logic             busy_r;
  logic             done_r;
  logic [DIM_W:0]   trial;

  assign trial = {rem_r[DIM_W-1:0], quo_r[NUM_W-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      quo_r  <= '0;
      rem_r  <= '0;
      den_r  <= '0;
      num_r  <= '0;
      cnt_r  <= '0;
      busy_r <= 1'b0;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (start_i) begin
        quo_r  <= {num_i, 16'h0000};
        rem_r  <= '0;
        den_r  <= den_i;
        num_r  <= num_i;
        cnt_r  <= CW'(NUM_W);
        busy_r <= 1'b1;
      end else if (busy_r) begin
        if (trial >= {1'b0, den_r}) begin
          rem_r <= trial - {1'b0, den_r};
          quo_r <= {quo_r[NUM_W-2:0], 1'b1};
        end else begin
          rem_r <= trial;
          quo_r <= {quo_r[NUM_W-2:0], 1'b0};
        end
        cnt_r <= cnt_r - CW'(1);
        if (cnt_r == CW'(1)) begin
          busy_r <= 1'b0;
          done_r <= 1'b1;
        end
      end
    end
  end

  assign quo_o  = quo_r;
  assign done_o = done_r;

  // R8
  ratio_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (done_r && den_r != '0) |->
      ((PW'(quo_r) * PW'(den_r) <= PW'({num_r, 16'h0000})) &&
       (PW'({num_r, 16'h0000}) < (PW'(quo_r) + PW'(1)) * PW'(den_r))));

endmodule

// File: rtl/sgc_slot_pick.sv
module sgc_slot_pick #(
  parameter int NUM_SCALERS = 2,
  parameter int SW          = 1
) (
  input  logic [NUM_SCALERS-1:0] busy_i,
  output logic                   found_o,
  output logic [SW-1:0]          idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_SCALERS - 1; i >= 0; i--) begin
      if (!busy_i[i]) begin
        found_o = 1'b1;
        idx_o   = SW'(i);
      end
    end
  end
endmodule

// File: rtl/scaler_grant_ctrl.sv
module scaler_grant_ctrl
  import sgc_pkg::*;
#(
  parameter int NUM_USERS      = 4,
  parameter int NUM_SCALERS    = 2,
  parameter int DIM_W          = 14,
  parameter int NEWEST_VARIANT = 0,
  localparam int UW = (NUM_USERS > 1) ? $clog2(NUM_USERS) : 1,
  localparam int SW = (NUM_SCALERS > 1) ? $clog2(NUM_SCALERS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [UW-1:0]          req_user,
  input  logic [DIM_W-1:0]       req_src_w,
  input  logic [DIM_W-1:0]       req_src_h,
  input  logic [DIM_W-1:0]       req_dst_w,
  input  logic [DIM_W-1:0]       req_dst_h,
  input  logic                   req_semiplanar,
  input  logic                   req_hdr_plane,
  input  logic                   req_interlaced,
  input  logic                   req_out420,
  input  logic                   rel_valid,
  output logic                   rel_ready,
  input  logic [UW-1:0]          rel_user,
  output logic                   resp_valid,
  output logic [UW-1:0]          resp_user,
  output logic [2:0]             resp_code,
  output logic [SW-1:0]          resp_scaler,
  output logic [NUM_SCALERS-1:0] scaler_busy,
  output logic [NUM_SCALERS-1:0] scaler_hq
);
  localparam int NUM_W = DIM_W + 16;
  localparam int CNTW  = $clog2(NUM_USERS + 1);
  localparam logic [UW-1:0]    PIPE_USER = UW'(NUM_USERS - 1);
  localparam logic [DIM_W-1:0] MIN_SP    = DIM_W'(MIN_SRC_PLAIN);
  localparam logic [DIM_W-1:0] MIN_SS    = DIM_W'(MIN_SRC_SEMI);
  localparam logic [DIM_W-1:0] MIN_D     = DIM_W'(MIN_DST);

  ctrl_state_e state;

  logic [UW-1:0]    r_user;
  logic [DIM_W-1:0] r_sw, r_sh, r_dw, r_dh;
  logic             r_semi, r_hdr, r_intl, r_o420;

  logic [NUM_USERS-1:0] user_has;
  logic [SW-1:0]        user_sid [NUM_USERS];
  logic [NUM_SCALERS-1:0] busy_r, hq_r;

  logic [SW-1:0] cand_r;
  logic          cand_hq_r;
  logic          multi_r;

  resp_code_e    resp_code_r;

  // ---------------- check stage ----------------
  logic                 need;
  logic                 size_bad;
  logic [NUM_USERS-1:0] mask_next;
  logic [CNTW-1:0]      new_cnt;
  logic                 held;
  logic [SW-1:0]        hid;
  logic                 free_found;
  logic [SW-1:0]        free_idx;
  logic [SW-1:0]        cand;
  logic                 single;
  logic                 over_cnt;
  logic                 div_start;

  sgc_slot_pick #(.NUM_SCALERS(NUM_SCALERS), .SW(SW)) pick_i (
    .busy_i  (busy_r),
    .found_o (free_found),
    .idx_o   (free_idx)
  );

  always_comb begin
    need      = (r_sw != r_dw) || (r_sh != r_dh) || (r_semi && !r_hdr);
    size_bad  = (r_sw < (r_semi ? MIN_SS : MIN_SP)) ||
                (r_sh < (r_semi ? MIN_SS : MIN_SP)) ||
                (r_dw < MIN_D) || (r_dh < MIN_D);
    mask_next = user_has | (NUM_USERS'(1) << r_user);
    new_cnt   = '0;
    for (int i = 0; i < NUM_USERS; i++) new_cnt = new_cnt + CNTW'(mask_next[i]);
    over_cnt  = int'(new_cnt) > NUM_SCALERS;
    held      = user_has[r_user];
    hid       = user_sid[r_user];
    single    = (new_cnt == CNTW'(1)) && (NUM_SCALERS > 1);
    if (single)    cand = '0;
    else if (held) cand = hid;
    else           cand = free_idx;
    div_start = (state == ST_CHECK) && need && !r_intl && !size_bad &&
                !over_cnt && (held || free_found || single);
  end

  // ---------------- ratio stage ----------------
  logic [NUM_W-1:0] h_ratio, v_ratio;
  logic             h_done, v_done;
  logic [NUM_W-1:0] h_lim, v_lim;
  logic             ratio_bad;

  sgc_ratio_div #(.DIM_W(DIM_W)) hdiv_i (
    .clk(clk), .rst(rst), .start_i(div_start),
    .num_i(r_sw), .den_i(r_dw), .quo_o(h_ratio), .done_o(h_done)
  );

  sgc_ratio_div #(.DIM_W(DIM_W)) vdiv_i (
    .clk(clk), .rst(rst), .start_i(div_start),
    .num_i(r_sh), .den_i(r_dh), .quo_o(v_ratio), .done_o(v_done)
  );

  always_comb begin
    if (r_user == PIPE_USER && r_o420) begin
      h_lim = NUM_W'(LIM_H420);
      v_lim = NUM_W'(LIM_UNITY);
    end else begin
      h_lim = NUM_W'(LIM_FULL);
      v_lim = (NEWEST_VARIANT != 0 && cand_r != '0) ? NUM_W'(LIM_UNITY)
                                                    : NUM_W'(LIM_FULL);
    end
    ratio_bad = (h_ratio > h_lim) || (v_ratio > v_lim);
  end

  // ---------------- state and pool ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      r_user      <= '0;
      r_sw        <= '0;
      r_sh        <= '0;
      r_dw        <= '0;
      r_dh        <= '0;
      r_semi      <= 1'b0;
      r_hdr       <= 1'b0;
      r_intl      <= 1'b0;
      r_o420      <= 1'b0;
      user_has    <= '0;
      for (int u = 0; u < NUM_USERS; u++) user_sid[u] <= '0;
      busy_r      <= '0;
      hq_r        <= '0;
      cand_r      <= '0;
      cand_hq_r   <= 1'b0;
      multi_r     <= 1'b0;
      resp_valid  <= 1'b0;
      resp_user   <= '0;
      resp_code_r <= RC_GRANT;
      resp_scaler <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (rel_valid) begin
            if (user_has[rel_user]) begin
              busy_r[user_sid[rel_user]] <= 1'b0;
              hq_r[user_sid[rel_user]]   <= 1'b0;
              user_has[rel_user]         <= 1'b0;
            end
          end else if (req_valid) begin
            r_user <= req_user;
            r_sw   <= req_src_w;
            r_sh   <= req_src_h;
            r_dw   <= req_dst_w;
            r_dh   <= req_dst_h;
            r_semi <= req_semiplanar;
            r_hdr  <= req_hdr_plane;
            r_intl <= req_interlaced;
            r_o420 <= req_out420;
            state  <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          resp_user   <= r_user;
          resp_scaler <= '0;
          if (div_start) begin
            cand_r    <= cand;
            cand_hq_r <= single;
            multi_r   <= new_cnt > CNTW'(1);
            state     <= ST_DIV;
          end else begin
            resp_valid <= 1'b1;
            state      <= ST_IDLE;
            if (!need) begin
              resp_code_r <= RC_BYPASS;
              if (held) begin
                busy_r[hid]      <= 1'b0;
                hq_r[hid]        <= 1'b0;
                user_has[r_user] <= 1'b0;
              end
            end else if (r_intl)  resp_code_r <= RC_INTERLACE;
            else if (size_bad)    resp_code_r <= RC_SIZE;
            else                  resp_code_r <= RC_COUNT;
          end
        end
        ST_DIV: begin
          if (h_done && v_done) begin
            resp_valid <= 1'b1;
            state      <= ST_IDLE;
            if (ratio_bad) begin
              resp_code_r <= RC_RATIO;
            end else begin
              resp_code_r <= RC_GRANT;
              resp_scaler <= cand_r;
              if (user_has[r_user] && user_sid[r_user] != cand_r) begin
                busy_r[user_sid[r_user]] <= 1'b0;
                hq_r[user_sid[r_user]]   <= 1'b0;
              end
              if (multi_r) hq_r <= '0;
              busy_r[cand_r]   <= 1'b1;
              hq_r[cand_r]     <= cand_hq_r;
              user_has[r_user] <= 1'b1;
              user_sid[r_user] <= cand_r;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (state == ST_IDLE) && !rel_valid;
  assign rel_ready   = (state == ST_IDLE);
  assign resp_code   = resp_code_r;
  assign scaler_busy = busy_r;
  assign scaler_hq   = hq_r;

  // R7
  hq_single_chk: assert property (@(posedge clk) disable iff (rst)
    (|scaler_hq) |-> ($countones(scaler_busy) == 1 && $countones(scaler_hq) == 1));

  // R6
  grant_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_code == 3'(RC_GRANT)) |-> scaler_busy[resp_scaler]);

  // R12
  resp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

  // R11
  release_free_chk: assert property (@(posedge clk) disable iff (rst)
    (rel_valid && rel_ready) |=> ($countones(scaler_busy) <= $countones($past(scaler_busy))));

  // R12
  busy_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/scaler_grant_ctrl_tb_top.sv
`timescale 1ns/1ps
module scaler_grant_ctrl_tb_top;
  localparam int NU = 4;
  localparam int NS = 2;
  localparam int DW = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0, req_ready;
  logic [1:0]    req_user = '0;
  logic [DW-1:0] req_src_w = '0, req_src_h = '0, req_dst_w = '0, req_dst_h = '0;
  logic          req_semiplanar = 0, req_hdr_plane = 0, req_interlaced = 0, req_out420 = 0;
  logic          rel_valid = 1'b0, rel_ready;
  logic [1:0]    rel_user = '0;
  logic          resp_valid;
  logic [1:0]    resp_user;
  logic [2:0]    resp_code;
  logic [0:0]    resp_scaler;
  logic [NS-1:0] scaler_busy, scaler_hq;

  scaler_grant_ctrl #(.NUM_USERS(NU), .NUM_SCALERS(NS), .DIM_W(DW), .NEWEST_VARIANT(1)) dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_user(req_user),
    .req_src_w(req_src_w), .req_src_h(req_src_h), .req_dst_w(req_dst_w), .req_dst_h(req_dst_h),
    .req_semiplanar(req_semiplanar), .req_hdr_plane(req_hdr_plane),
    .req_interlaced(req_interlaced), .req_out420(req_out420),
    .rel_valid(rel_valid), .rel_ready(rel_ready), .rel_user(rel_user),
    .resp_valid(resp_valid), .resp_user(resp_user), .resp_code(resp_code),
    .resp_scaler(resp_scaler), .scaler_busy(scaler_busy), .scaler_hq(scaler_hq)
  );

  int n_chk = 0;
  int n_err = 0;

  // model
  bit m_busy [NS];
  bit m_hq   [NS];
  bit m_has  [NU];
  int m_sid  [NU];

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic longint ratio(input int s, input int d);
    return (longint'(s) * 65536) / d;
  endfunction

  function automatic int vec_busy();
    return (m_busy[1] ? 2 : 0) + (m_busy[0] ? 1 : 0);
  endfunction

  function automatic int vec_hq();
    return (m_hq[1] ? 2 : 0) + (m_hq[0] ? 1 : 0);
  endfunction

  function automatic string code_tag(input int c);
    case (c)
      0: return "R6";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic do_req(input int u, input int sw, input int sh, input int dw, input int dh,
                        input bit semi, input bit hdr, input bit intl, input bit o420,
                        input string tag_in);
    int e_code, e_sid, cnt, cand, mn, n;
    longint hr, vr, hl, vl;
    bit need;
    string tag;
    e_sid = 0;
    need = (sw != dw) || (sh != dh) || (semi && !hdr);
    mn = semi ? 16 : 8;
    if (!need) begin
      e_code = 1;
      if (m_has[u]) begin
        m_busy[m_sid[u]] = 0; m_hq[m_sid[u]] = 0; m_has[u] = 0;
      end
    end else if (intl) e_code = 2;
    else if (sw < mn || sh < mn || dw < 8 || dh < 8) e_code = 3;
    else begin
      cnt = m_has[u] ? 0 : 1;
      for (int i = 0; i < NU; i++) cnt += m_has[i] ? 1 : 0;
      if (cnt > NS) e_code = 4;
      else begin
        if (cnt == 1) cand = 0;
        else if (m_has[u]) cand = m_sid[u];
        else cand = m_busy[0] ? 1 : 0;
        hr = ratio(sw, dw); vr = ratio(sh, dh);
        if (u == NU - 1 && o420) begin hl = 'h17FFF; vl = 'h10000; end
        else begin hl = 'h2FFFF; vl = (cand != 0) ? 'h10000 : 'h2FFFF; end
        if (hr > hl || vr > vl) e_code = 5;
        else begin
          e_code = 0; e_sid = cand;
          if (m_has[u] && m_sid[u] != cand) begin m_busy[m_sid[u]] = 0; m_hq[m_sid[u]] = 0; end
          if (cnt > 1) for (int i = 0; i < NS; i++) m_hq[i] = 0;
          m_busy[cand] = 1; m_hq[cand] = (cnt == 1);
          m_has[u] = 1; m_sid[u] = cand;
        end
      end
    end
    tag = (tag_in == "") ? code_tag(e_code) : tag_in;

    while (!req_ready) @(negedge clk);
    req_user = 2'(u); req_src_w = DW'(sw); req_src_h = DW'(sh);
    req_dst_w = DW'(dw); req_dst_h = DW'(dh);
    req_semiplanar = semi; req_hdr_plane = hdr; req_interlaced = intl; req_out420 = o420;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12", "req_ready after accept", req_ready, 0);
    n = 0;
    while (!resp_valid && n < 200) begin @(negedge clk); n++; end
    chk("R12", "response arrived", resp_valid, 1);
    chk(tag, "resp_code", resp_code, e_code);
    chk(tag, "resp_user", resp_user, u);
    if (e_code == 0) chk(tag, "resp_scaler", resp_scaler, e_sid);
    chk(tag, "scaler_busy", scaler_busy, vec_busy());
    chk((e_code == 0) ? "R7" : tag, "scaler_hq", scaler_hq, vec_hq());
    @(negedge clk);
    chk("R12", "resp single pulse", resp_valid, 0);
  endtask

  task automatic do_rel(input int u);
    while (!rel_ready) @(negedge clk);
    rel_user = 2'(u); rel_valid = 1'b1;
    #1;
    chk("R12", "req_ready low during release", req_ready, 0);
    @(negedge clk);
    rel_valid = 1'b0;
    if (m_has[u]) begin m_busy[m_sid[u]] = 0; m_hq[m_sid[u]] = 0; m_has[u] = 0; end
    chk("R11", "busy after release", scaler_busy, vec_busy());
    chk("R11", "hq after release", scaler_hq, vec_hq());
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < NS; i++) begin m_busy[i] = 0; m_hq[i] = 0; end
    for (int i = 0; i < NU; i++) begin m_has[i] = 0; m_sid[i] = 0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "busy after reset", scaler_busy, 0);
    chk("R1", "hq after reset", scaler_hq, 0);
    chk("R1", "resp_valid after reset", resp_valid, 0);
    chk("R1", "req_ready after reset", req_ready, 1);

    do_req(0, 8, 8, 8, 8, 0, 0, 0, 0, "R2");          // no scaling
    do_req(0, 16, 16, 16, 16, 1, 0, 0, 0, "R7");      // semiplanar forces a scaler; single user HQ
    do_req(1, 100, 100, 50, 50, 0, 0, 0, 0, "R9");    // vertical 2.0 on scaler 1
    do_req(1, 50, 50, 100, 100, 0, 0, 0, 0, "R6");    // second user, scaler 1
    do_req(2, 20, 20, 10, 10, 0, 0, 0, 0, "R5");      // pool full
    do_req(2, 4, 4, 8, 8, 0, 0, 1, 0, "R3");          // interlace outranks size
    do_rel(1);
    do_req(2, 12, 20, 20, 20, 1, 0, 0, 0, "R4");      // semiplanar min 16
    do_req(2, 20, 20, 7, 20, 0, 0, 0, 0, "R4");       // dst min 8
    do_req(2, 30, 10, 10, 10, 0, 0, 0, 0, "R8");      // exactly 3.0 rejected
    do_req(2, 29, 10, 10, 10, 0, 0, 0, 0, "R8");      // under 3.0 granted
    do_rel(2);
    do_rel(3);                                         // holder of nothing
    do_req(3, 15, 10, 10, 10, 0, 0, 0, 1, "R10");     // 1.5 horizontal rejected
    do_req(3, 14, 11, 10, 10, 0, 0, 0, 1, "R10");     // vertical 1.1 rejected
    do_req(3, 14, 10, 10, 10, 0, 0, 0, 1, "R10");     // granted
    do_req(3, 40, 40, 40, 40, 0, 0, 0, 0, "R2");      // bypass frees scaler
    do_rel(0);
    do_req(1, 100, 100, 40, 40, 0, 0, 0, 0, "R7");    // single user, scaler 0, 2.5

    for (int k = 0; k < 320; k++) begin
      int u, sw, sh, dw, dh;
      u = $urandom_range(0, NU - 1);
      if ($urandom_range(0, 4) == 0) do_rel(u);
      else begin
        sw = $urandom_range(6, 90); sh = $urandom_range(6, 90);
        if ($urandom_range(0, 3) == 0) begin dw = sw; dh = sh; end
        else begin dw = $urandom_range(6, 90); dh = $urandom_range(6, 90); end
        do_req(u, sw, sh, dw, dh, ($urandom_range(0, 3) == 0), $urandom_range(0, 1) == 1,
               ($urandom_range(0, 15) == 0), ($urandom_range(0, 3) == 0), "");
      end
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule